// File: doc/BRIEF.md
# Byte-Serial DES Data Block Register

This block holds the 64-bit data block of a DES datapath as a left half and a right half of 32 bits each. Each half is made of four 8-bit shift lanes. Each bit of the 8-bit byte port is wired to exactly one lane. A block enters as eight successive bytes, and the standard initial permutation comes out of that wiring and the serial shifting alone. No lookup table is involved. After the round logic has finished, the block leaves as eight successive bytes in right-then-left order, and the same wiring produces the final permutation.

External round logic exchanges whole halves with the block through a parallel load strobe and two always-visible 32-bit parallel outputs. A small controller drives the load and unload sequences:

- a byte counter tracks progress through each sequence;
- valid/ready handshakes sit on both byte streams;
- one-cycle done pulses mark the end of a load and the end of an unload.

Top module: `des_block_reg`

## Requirements
- R1: Port bits are numbered 1 to 8 from most to least significant: port bit n is `dataIn[8-n]` on input and `dataOut[8-n]` on output.
- R2: After eight accepted bytes (byte k carrying block bits 8k-7..8k, block bit 1 in `dataIn[7]` of the first byte), `parOutL`/`parOutR` equal the initially permuted left/right halves. Half bit 1 sits in bit 31. Port bits 2,4,6,8 feed left-half bits 1-8, 9-16, 17-24, 25-32, and port bits 1,3,5,7 feed the same right-half ranges. The last byte lands in half-bit positions 1, 9, 17, 25.
- R3: An unload emits the final permutation of the pre-output block (right half = bits 1-32, left half = bits 33-64). The first byte is bits 40, 8, 48, 16, 56, 24, 64, 32 on port bits 1..8, and byte k uses bit offsets reduced by k-1.
- R4: Loading a block and unloading it with no parallel load in between returns every byte with port bits 1/2, 3/4, 5/6 and 7/8 swapped.
- R5: `parLoad` replaces both halves with `parInL`/`parInR` at the next clock edge, and the halves are continuously visible on `parOutL`/`parOutR`.
- R6: When `parLoad` is high, no serial shift takes place, `inReady` is low, and the byte counter holds.
- R7: `loadDone` pulses for exactly one cycle, in the cycle after the eighth accepted byte of a load, and at no other time.
- R8: `unloadReq` in the idle state starts an unload. `outValid` then stays high until eight bytes have been taken with `outReady` high. `dataOut` holds while `outReady` is low. `unloadDone` pulses for one cycle after the eighth byte.
- R9: While an unload is in progress, `inReady` is low and `inValid`/`dataIn` have no effect on the output bytes or on the halves. The unload shifts zeros in, so both halves read zero afterwards.
- R10: `unloadReq` is ignored while a load is part-way through. In the idle state, `unloadReq` takes precedence over `inValid` in the same cycle.
- R11: After reset, both halves are zero, `inReady` is high, and `outValid`, `loadDone` and `unloadDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 8 | Input byte, port bit 1 in the MSB |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte can be taken this cycle |
| dataOut | output | 8 | Output byte, port bit 1 in the MSB |
| outValid | output | 1 | Output byte valid (unload in progress) |
| outReady | input | 1 | Receiver takes the output byte |
| unloadReq | input | 1 | Start an unload |
| loadDone | output | 1 | One-cycle pulse after the eighth loaded byte |
| unloadDone | output | 1 | One-cycle pulse after the eighth unloaded byte |
| parLoad | input | 1 | Parallel load of both halves |
| parInL | input | 32 | Left half from the round logic, bit 1 in the MSB |
| parInR | input | 32 | Right half from the round logic, bit 1 in the MSB |
| parOutL | output | 32 | Current left half, bit 1 in the MSB |
| parOutR | output | 32 | Current right half, bit 1 in the MSB |

## Verification
The load and unload paths are driven with five blocks, each chosen to separate a different class of wiring fault:

- a mixed hexadecimal block;
- a block with only its first and last bits set;
- a block of alternating odd and even bits;
- a block with a high half and a low half;
- a block with only its low byte set.

The single-bit block exposes misplaced lanes and a reversed shift direction. The alternating block shows whether odd and even port bits are crossed between halves. The split block shows whether the halves are swapped or the right-then-left output order is reversed.

Each block is checked three ways: against the initial permutation on the parallel outputs, against the pairwise swap on a load/unload round trip, and against the final permutation after a parallel load.

// File: rtl/des_blk_pkg.sv
package des_blk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_UNLOAD = 2'd2
  } blkState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic parEn;     // replace both halves from the parallel inputs
    logic shiftEn;   // one serial step on every lane
    logic takeData;  // serial input comes from the port (else zero)
  } dpCtl_t;

endpackage

// File: rtl/des_lane_reg.sv
// One shift lane: parallel load wins over a serial step; a serial step moves
// every bit one place toward the LSB and enters the new bit at the MSB.
module des_lane_reg #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           parEn,
  input  logic           shiftEn,
  input  logic           serIn,
  input  logic [LEN-1:0] parIn,
  output logic [LEN-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      q <= '0;
    end else if (parEn) begin
      q <= parIn;
    end else if (shiftEn) begin
      q <= {serIn, q[LEN-1:1]};
    end
  end

endmodule

// File: rtl/des_blk_datapath.sv
// Left and right halves built from byte lanes; the lane wiring to the byte
// port realises the initial and final permutations.
module des_blk_datapath
  import des_blk_pkg::*;
#(
  parameter int LANE_LEN       = 8,
  parameter int LANES_PER_HALF = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  dpCtl_t                              ctl,
  input  logic [2*LANES_PER_HALF-1:0]         dataIn,
  output logic [2*LANES_PER_HALF-1:0]         dataOut,
  input  logic [LANE_LEN*LANES_PER_HALF-1:0]  parInL,
  input  logic [LANE_LEN*LANES_PER_HALF-1:0]  parInR,
  output logic [LANE_LEN*LANES_PER_HALF-1:0]  parOutL,
  output logic [LANE_LEN*LANES_PER_HALF-1:0]  parOutR
);

  localparam int PORT_W = 2 * LANES_PER_HALF;
  localparam int HALF_W = LANE_LEN * LANES_PER_HALF;

  for (genvar j = 0; j < LANES_PER_HALF; j++) begin : g_lane
    // port bit 2j+2 feeds left lane j, port bit 2j+1 feeds right lane j
    localparam int IN_L  = PORT_W - 2*j - 2;
    localparam int IN_R  = PORT_W - 2*j - 1;
    // on output, left lane j drives port bit 2j+1, right lane j port bit 2j+2
    localparam int OUT_L = PORT_W - 2*j - 1;
    localparam int OUT_R = PORT_W - 2*j - 2;
    localparam int TOP   = HALF_W - 1 - j*LANE_LEN;

    logic [LANE_LEN-1:0] laneL;
    logic [LANE_LEN-1:0] laneR;

    des_lane_reg #(.LEN(LANE_LEN)) i_laneL (
      .clk    (clk),
      .rstN   (rstN),
      .parEn  (ctl.parEn),
      .shiftEn(ctl.shiftEn),
      .serIn  (ctl.takeData & dataIn[IN_L]),
      .parIn  (parInL[TOP -: LANE_LEN]),
      .q      (laneL)
    );

    des_lane_reg #(.LEN(LANE_LEN)) i_laneR (
      .clk    (clk),
      .rstN   (rstN),
      .parEn  (ctl.parEn),
      .shiftEn(ctl.shiftEn),
      .serIn  (ctl.takeData & dataIn[IN_R]),
      .parIn  (parInR[TOP -: LANE_LEN]),
      .q      (laneR)
    );

    assign parOutL[TOP -: LANE_LEN] = laneL;
    assign parOutR[TOP -: LANE_LEN] = laneR;
    assign dataOut[OUT_L]           = laneL[0];
    assign dataOut[OUT_R]           = laneR[0];
  end

  // parallel load takes precedence over any serial step
  p_par_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.parEn |=> (parOutL == $past(parInL)) && (parOutR == $past(parInR)));

  // halves move only when the controller strobes them
  p_halves_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.parEn && !ctl.shiftEn) |=> $stable(parOutL) && $stable(parOutR));

endmodule

// File: rtl/des_blk_ctrl.sv
// Sequencer: byte counter, load/unload handshakes and done pulses.
module des_blk_ctrl
  import des_blk_pkg::*;
#(
  parameter int LANE_LEN = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   unloadReq,
  input  logic   outReady,
  input  logic   parLoad,
  output dpCtl_t ctl,
  output logic   inReady,
  output logic   outValid,
  output logic   loadDone,
  output logic   unloadDone
);

  localparam int                CNT_W = (LANE_LEN > 1) ? $clog2(LANE_LEN) : 1;
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(LANE_LEN - 1);

  blkState_t        state;
  logic [CNT_W-1:0] byteCnt;
  logic             unloading;
  logic             startUnload;
  logic             takeIn;
  logic             takeOut;
  logic             lastByte;

  always_comb begin
    unloading   = (state == ST_UNLOAD);
    startUnload = (state == ST_IDLE) && unloadReq;
    inReady     = !unloading && !parLoad && !startUnload;
    outValid    = unloading;
    takeIn      = inValid && inReady;
    takeOut     = unloading && outReady && !parLoad;
    lastByte    = (byteCnt == LAST);
    ctl.parEn    = parLoad;
    ctl.shiftEn  = takeIn || takeOut;
    ctl.takeData = takeIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      byteCnt    <= '0;
      loadDone   <= 1'b0;
      unloadDone <= 1'b0;
    end else begin
      loadDone   <= takeIn && lastByte;
      unloadDone <= takeOut && lastByte;
      unique case (state)
        ST_IDLE: begin
          if (startUnload) begin
            state   <= ST_UNLOAD;
            byteCnt <= '0;
          end else if (takeIn) begin
            state   <= lastByte ? ST_IDLE : ST_LOAD;
            byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (takeIn) begin
            state   <= lastByte ? ST_IDLE : ST_LOAD;
            byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
          end
        end
        ST_UNLOAD: begin
          if (takeOut) begin
            state   <= lastByte ? ST_IDLE : ST_UNLOAD;
            byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
          end
        end
        default: begin
          state   <= ST_IDLE;
          byteCnt <= '0;
        end
      endcase
    end
  end

  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  p_load_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  p_unload_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    unloadDone |-> !outValid && !$past(unloadDone));

  p_no_unload_midload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |=> !outValid);

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    parLoad |=> $stable(byteCnt));

endmodule

// File: rtl/des_block_reg.sv
// Thin top: byte-serial DES data block register.
module des_block_reg
  import des_blk_pkg::*;
#(
  parameter int LANE_LEN       = 8,
  parameter int LANES_PER_HALF = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [2*LANES_PER_HALF-1:0]        dataIn,
  input  logic                               inValid,
  output logic                               inReady,
  output logic [2*LANES_PER_HALF-1:0]        dataOut,
  output logic                               outValid,
  input  logic                               outReady,
  input  logic                               unloadReq,
  output logic                               loadDone,
  output logic                               unloadDone,
  input  logic                               parLoad,
  input  logic [LANE_LEN*LANES_PER_HALF-1:0] parInL,
  input  logic [LANE_LEN*LANES_PER_HALF-1:0] parInR,
  output logic [LANE_LEN*LANES_PER_HALF-1:0] parOutL,
  output logic [LANE_LEN*LANES_PER_HALF-1:0] parOutR
);

  dpCtl_t ctl;

  des_blk_ctrl #(.LANE_LEN(LANE_LEN)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .unloadReq (unloadReq),
    .outReady  (outReady),
    .parLoad   (parLoad),
    .ctl       (ctl),
    .inReady   (inReady),
    .outValid  (outValid),
    .loadDone  (loadDone),
    .unloadDone(unloadDone)
  );

  des_blk_datapath #(
    .LANE_LEN      (LANE_LEN),
    .LANES_PER_HALF(LANES_PER_HALF)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .parInL (parInL),
    .parInR (parInR),
    .parOutL(parOutL),
    .parOutR(parOutR)
  );

  // a stalled output byte stays put and stays valid
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !parLoad) |=> outValid && $stable(dataOut));

  // idle request wins over a same-cycle input byte
  p_req_prio_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && !inReady && unloadReq && !parLoad) |=> outValid);

endmodule

// File: tb/test_des_block_reg.sv
module test_des_block_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  dataOut;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        unloadReq = 1'b0;
  logic        loadDone;
  logic        unloadDone;
  logic        parLoad = 1'b0;
  logic [31:0] parInL = '0;
  logic [31:0] parInR = '0;
  logic [31:0] parOutL;
  logic [31:0] parOutR;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  des_block_reg i_des_block_reg (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .inValid(inValid), .inReady(inReady),
    .dataOut(dataOut), .outValid(outValid), .outReady(outReady), .unloadReq(unloadReq),
    .loadDone(loadDone), .unloadDone(unloadDone), .parLoad(parLoad),
    .parInL(parInL), .parInR(parInR), .parOutL(parOutL), .parOutR(parOutR)
  );

  localparam int NVEC = 5;
  localparam logic [63:0] VECS [NVEC] = '{
    64'h0123456789ABCDEF,
    64'h8000000000000001,
    64'hAAAAAAAA55555555,
    64'hFFFFFFFF00000000,
    64'h00000000000000FF
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte k (1..8) of a block, block bit 1 is the MSB
  function automatic logic [7:0] byteOf(input logic [63:0] v, input int k);
    return v[63-8*(k-1) -: 8];
  endfunction

  // initial permutation of one half, half bit 1 in bit 31
  function automatic logic [31:0] ipHalf(input logic [63:0] blk, input bit left);
    logic [31:0] h;
    for (int p = 1; p <= 32; p++) begin
      int r = (p - 1) / 8;
      int c = (p - 1) % 8;
      int src = 8*(7 - c) + 2*r + (left ? 2 : 1);
      h[32-p] = blk[64-src];
    end
    return h;
  endfunction

  // final permutation of R16L16 as an eight-byte stream
  function automatic logic [63:0] fpStream(input logic [31:0] l, input logic [31:0] r);
    logic [63:0] pre = {r, l};
    logic [63:0] s;
    for (int k = 1; k <= 8; k++) begin
      for (int n = 1; n <= 8; n++) begin
        int idx = (n % 2 == 1) ? 32 + 8*((n - 1)/2) + (9 - k) : 8*(n/2 - 1) + (9 - k);
        s[64 - 8*(k-1) - n] = pre[64-idx];
      end
    end
    return s;
  endfunction

  function automatic logic [63:0] swapStream(input logic [63:0] v);
    logic [63:0] s;
    for (int i = 0; i < 32; i++) begin
      s[2*i]   = v[2*i+1];
      s[2*i+1] = v[2*i];
    end
    return s;
  endfunction

  // send bytes firstK..lastK of a block; checks loadDone timing (R7)
  task automatic loadBytes(input logic [63:0] v, input int firstK, input int lastK,
                           input bit expectDone);
    for (int k = firstK; k <= lastK; k++) begin
      @(negedge clk);
      if (k > firstK) check(loadDone == 1'b0, "R7 early loadDone", 64'(loadDone), 64'd0);
      dataIn  = byteOf(v, k);
      inValid = 1'b1;
    end
    @(negedge clk);
    inValid = 1'b0;
    check(loadDone == expectDone, "R7 loadDone after last byte", 64'(loadDone), 64'(expectDone));
    @(negedge clk);
    check(loadDone == 1'b0, "R7 loadDone one cycle", 64'(loadDone), 64'd0);
  endtask

  // unload and compare against an expected byte stream (R3/R4/R8/R9)
  task automatic unloadCheck(input logic [63:0] exp, input string req,
                             input int stallAt, input bit noisyIn);
    @(negedge clk);
    unloadReq = 1'b1;
    outReady  = 1'b1;
    @(negedge clk);
    unloadReq = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      check(outValid == 1'b1, "R8 outValid during unload", 64'(outValid), 64'd1);
      check(dataOut == byteOf(exp, k), req, 64'(dataOut), 64'(byteOf(exp, k)));
      if (noisyIn) begin
        inValid = 1'b1;
        dataIn  = 8'hFF;
        check(inReady == 1'b0, "R9 inReady low in unload", 64'(inReady), 64'd0);
      end
      if (k == stallAt) begin
        outReady = 1'b0;
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          check(outValid && dataOut == byteOf(exp, k), "R8 byte held on stall",
                64'(dataOut), 64'(byteOf(exp, k)));
        end
        outReady = 1'b1;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
    check(outValid == 1'b0, "R8 outValid drops", 64'(outValid), 64'd0);
    check(unloadDone == 1'b1, "R8 unloadDone pulse", 64'(unloadDone), 64'd1);
    @(negedge clk);
    check(unloadDone == 1'b0, "R8 unloadDone one cycle", 64'(unloadDone), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(inReady == 1'b1 && outValid == 1'b0 && loadDone == 1'b0 && unloadDone == 1'b0,
          "R11 reset flags", {inReady, outValid, loadDone, unloadDone}, 64'h8);
    check(parOutL == 32'd0 && parOutR == 32'd0, "R11 reset halves", {parOutL, parOutR}, 64'd0);
    rstN = 1'b1;

    // vector table: load, round trip, parallel load, final permutation
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] v = VECS[i];
      loadBytes(v, 1, 8, 1'b1);
      check(parOutL == ipHalf(v, 1'b1), "R2 left half after load", 64'(parOutL), 64'(ipHalf(v, 1'b1)));
      check(parOutR == ipHalf(v, 1'b0), "R2 right half after load", 64'(parOutR), 64'(ipHalf(v, 1'b0)));
      unloadCheck(swapStream(v), "R4 R1 round-trip byte", 0, 1'b0);
      @(negedge clk);
      parLoad = 1'b1;
      parInL  = v[63:32];
      parInR  = v[31:0];
      @(negedge clk);
      parLoad = 1'b0;
      check(parOutL == v[63:32] && parOutR == v[31:0], "R5 parallel load", {parOutL, parOutR}, v);
      unloadCheck(fpStream(v[63:32], v[31:0]), "R3 final permutation byte", 0, 1'b0);
    end

    // R9: input bytes ignored during unload; zeros shifted in
    loadBytes(VECS[0], 1, 8, 1'b1);
    unloadCheck(swapStream(VECS[0]), "R9 unload with noisy input", 3, 1'b1);
    check(parOutL == 32'd0 && parOutR == 32'd0, "R9 halves cleared by unload",
          {parOutL, parOutR}, 64'd0);

    // R10: unload request ignored mid-load
    loadBytes(VECS[1], 1, 3, 1'b0);
    @(negedge clk);
    unloadReq = 1'b1;
    @(negedge clk);
    unloadReq = 1'b0;
    check(outValid == 1'b0 && inReady == 1'b1, "R10 no unload mid-load",
          {outValid, inReady}, 64'h1);
    loadBytes(VECS[1], 4, 8, 1'b1);
    check(parOutL == ipHalf(VECS[1], 1'b1), "R10 block intact", 64'(parOutL),
          64'(ipHalf(VECS[1], 1'b1)));

    // R10: idle unload request beats a same-cycle input byte
    @(negedge clk);
    unloadReq = 1'b1;
    inValid   = 1'b1;
    dataIn    = 8'hFF;
    outReady  = 1'b1;
    #1;
    check(inReady == 1'b0, "R10 inReady low on idle request", 64'(inReady), 64'd0);
    @(negedge clk);
    unloadReq = 1'b0;
    inValid   = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      check(dataOut == byteOf(swapStream(VECS[1]), k), "R10 unload after priority",
            64'(dataOut), 64'(byteOf(swapStream(VECS[1]), k)));
      @(negedge clk);
    end

    // R6: parallel load beats a same-cycle serial byte; counter holds
    loadBytes(VECS[2], 1, 3, 1'b0);
    @(negedge clk);
    parLoad = 1'b1;
    parInL  = 32'h13579BDF;
    parInR  = 32'h2468ACE0;
    inValid = 1'b1;
    dataIn  = byteOf(VECS[2], 4);
    #1;
    check(inReady == 1'b0, "R6 inReady low under parLoad", 64'(inReady), 64'd0);
    @(negedge clk);
    parLoad = 1'b0;
    inValid = 1'b0;
    check(parOutL == 32'h13579BDF && parOutR == 32'h2468ACE0, "R6 parallel wins",
          {parOutL, parOutR}, 64'h13579BDF2468ACE0);
    loadBytes(VECS[2], 4, 8, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule